// File: doc/BRIEF.md
# Predicated Vector Element Sequencer

This block walks a short vector operation one element per clock, driven by two predicate masks: one selects which source elements are consumed, the other selects which destination elements are written. A source cursor and a destination cursor each jump forward to the next enabled element of their own mask. Every cycle in which both cursors find an enabled element produces one element pair. The pair is handed to a scalar datapath with a write enable. When one mask is sparse and the other is all ones, the result is compress behaviour (gaps in the source are closed up) or expand behaviour (dense source data is spread over the enabled destination slots).

Each mask either comes from an entry of a small register array, read once when the operation starts, or is forced to all ones by a per-mask "always" flag. In that case no entry is read. The datapath included for checking sign-extends the low byte of the source element and writes the result back into the same register array. A caller loads operands and reads results through a host port. It starts an operation with a one-cycle `start` pulse and waits for `done`.

Top module: `pred_vec_seq`

## Requirements
- R1: After reset `busy`, `done` and `elem_we` are 0, and every register array entry reads as 0 through the host read port.
- R2: When `src_always` (or `dst_always`) is 1, that side's mask is all ones and its mask-select input is not used. With both flags set, source element i is written to destination element i for i = 0 .. VL-1.
- R3: Compress: with a register source mask and `dst_always`=1, only source elements whose mask bit is 1 are used, in ascending order, and they go to destination elements 0, 1, 2, … . Mask bit 0 maps to element 0; for example VL=3 with mask 0b101 sends source 0 to destination 0 and source 2 to destination 1.
- R4: Expand: with `src_always`=1 and a register destination mask, source elements 0, 1, 2, … go in order to the destination elements whose mask bit is 1. Destination elements whose bit is 0 keep their value. For example VL=3 with mask 0b101 sends source 0 to destination 0 and source 1 to destination 2.
- R5: With both masks taken from registers, the two cursors advance independently, each skipping its own cleared bits. The k-th enabled source element goes to the k-th enabled destination element.
- R6: The operation ends as soon as either cursor finds no enabled element below VL. Destination elements not written keep their value. Source elements beyond that point are not read.
- R7: `done` is high for exactly one cycle, in the cycle after the last element write, while `busy` is still 1. `busy` is 0 in the next cycle. With VL=0 there are no writes and `done` comes in the first cycle after `start`.
- R8: The written value is the low 8 bits of the source element sign-extended to the full data width (0x90 becomes 0xFFFF_FFFF_FFFF_FF90; 0x7F stays 0x7F).
- R9: At most one element write per cycle, with `elem_src_idx` and `elem_dst_idx` below VL. Each index strictly increases from one write to the next within an operation. Register addresses are the base plus the index, modulo the array size.
- R10: A `start` pulse while `busy` is 1 is ignored: the running operation finishes with its original settings, and nothing new begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation when idle |
| vl | input | 7 | Vector length (values above the data width are capped to it) |
| src_base | input | 5 | Array address of source element 0 |
| dst_base | input | 5 | Array address of destination element 0 |
| src_mask_sel | input | 5 | Array entry holding the source mask |
| dst_mask_sel | input | 5 | Array entry holding the destination mask |
| src_always | input | 1 | Source mask is all ones |
| dst_always | input | 1 | Destination mask is all ones |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| elem_we | output | 1 | Element write this cycle |
| elem_src_idx | output | 7 | Source element index of the current pair |
| elem_dst_idx | output | 7 | Destination element index of the current pair |
| host_we | input | 1 | Host write to the register array |
| host_addr | input | 5 | Host write address |
| host_wdata | input | 64 | Host write data |
| host_raddr | input | 5 | Host read address |
| host_rdata | output | 64 | Host read data (combinational) |

## Verification
The bench targets the two documented examples, VL=0, VL=1, all-zero masks and overlapping source, destination and mask entries. A design that read the mask after the first write, or tied the two cursors together, would leave the wrong destination slots changed. Every pair is compared in order against a bench model, and the write count is compared as well. This catches a sequencer that runs one element too far after one mask is exhausted, or that stalls on a cleared bit instead of skipping it. A start pulse in the middle of a run, and source bytes on both sides of 0x80, expose restart and sign-extension faults.

// File: rtl/pvs_pkg.sv
package pvs_pkg;
    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_e;
endpackage

// File: rtl/pvs_next_set.sv
// Priority search: lowest set bit of mask_i at or above from_i and below limit_i.
module pvs_next_set #(
    parameter int W  = 64,
    parameter int IW = 7
) (
    input  logic [W-1:0]  mask_i,
    input  logic [IW-1:0] from_i,
    input  logic [IW-1:0] limit_i,
    output logic          found_o,
    output logic [IW-1:0] pos_o
);
    always_comb begin
        found_o = 1'b0;
        pos_o   = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (mask_i[i] && (IW'(i) >= from_i) && (IW'(i) < limit_i)) begin
                found_o = 1'b1;
                pos_o   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/pvs_sext.sv
// Demonstration element operation: sign-extend the low byte.
module pvs_sext #(
    parameter int DW = 64
) (
    input  logic [DW-1:0] a_i,
    output logic [DW-1:0] y_o
);
    assign y_o = {{(DW - 8){a_i[7]}}, a_i[7:0]};
endmodule

// File: rtl/pvs_regfile.sv
// Register array with a sequencer write port (priority) and a host write port.
module pvs_regfile #(
    parameter int NREG = 32,
    parameter int DW   = 64,
    localparam int AW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          seq_we_i,
    input  logic [AW-1:0] seq_addr_i,
    input  logic [DW-1:0] seq_data_i,
    input  logic          ext_we_i,
    input  logic [AW-1:0] ext_addr_i,
    input  logic [DW-1:0] ext_data_i,
    output logic [DW-1:0] regs_o [NREG]
);
    for (genvar g = 0; g < NREG; g++) begin : g_entry
        logic [DW-1:0] ent_d, ent_q;
        always_comb begin
            ent_d = ent_q;
            if (ext_we_i && ext_addr_i == AW'(g)) ent_d = ext_data_i;
            if (seq_we_i && seq_addr_i == AW'(g)) ent_d = seq_data_i;
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ent_q <= '0;
            else        ent_q <= ent_d;
        end
        assign regs_o[g] = ent_q;
    end
endmodule

// File: rtl/pred_vec_seq.sv
// Predicated vector element sequencer with demo sign-extend datapath.
// NREG must be a power of two (addresses wrap modulo NREG).
module pred_vec_seq #(
    parameter int DW   = 64,
    parameter int NREG = 32,
    parameter int VL_W = 7,
    localparam int AW  = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [VL_W-1:0] vl,
    input  logic [AW-1:0]   src_base,
    input  logic [AW-1:0]   dst_base,
    input  logic [AW-1:0]   src_mask_sel,
    input  logic [AW-1:0]   dst_mask_sel,
    input  logic            src_always,
    input  logic            dst_always,
    output logic            busy,
    output logic            done,
    output logic            elem_we,
    output logic [VL_W-1:0] elem_src_idx,
    output logic [VL_W-1:0] elem_dst_idx,
    input  logic            host_we,
    input  logic [AW-1:0]   host_addr,
    input  logic [DW-1:0]   host_wdata,
    input  logic [AW-1:0]   host_raddr,
    output logic [DW-1:0]   host_rdata
);
    import pvs_pkg::*;

    localparam logic [VL_W-1:0] VL_CAP = VL_W'(DW);

    typedef struct packed {
        seq_state_e      st;
        logic [VL_W-1:0] vl;
        logic [VL_W-1:0] si;
        logic [VL_W-1:0] di;
        logic [DW-1:0]   smask;
        logic [DW-1:0]   dmask;
        logic [AW-1:0]   sbase;
        logic [AW-1:0]   dbase;
        logic            s_alw;
        logic            d_alw;
    } seq_t;

    seq_t q, d;

    logic [DW-1:0]   regs [NREG];
    logic            s_found, d_found;
    logic [VL_W-1:0] s_pos, d_pos;
    logic [AW-1:0]   rd_src_addr, wr_dst_addr;
    logic [DW-1:0]   wr_data;

    // signals brought out for the bound checker
    logic [VL_W-1:0] run_vl;
    logic            run_s_alw, run_d_alw;
    assign run_vl    = q.vl;
    assign run_s_alw = q.s_alw;
    assign run_d_alw = q.d_alw;

    pvs_next_set #(.W(DW), .IW(VL_W)) u_src_srch (
        .mask_i (q.smask), .from_i (q.si), .limit_i (q.vl),
        .found_o(s_found), .pos_o  (s_pos)
    );

    pvs_next_set #(.W(DW), .IW(VL_W)) u_dst_srch (
        .mask_i (q.dmask), .from_i (q.di), .limit_i (q.vl),
        .found_o(d_found), .pos_o  (d_pos)
    );

    assign rd_src_addr = q.sbase + AW'(s_pos);
    assign wr_dst_addr = q.dbase + AW'(d_pos);

    pvs_sext #(.DW(DW)) u_op (
        .a_i(regs[rd_src_addr]),
        .y_o(wr_data)
    );

    pvs_regfile #(.NREG(NREG), .DW(DW)) u_rf (
        .clk       (clk),
        .rst_n     (rst_n),
        .seq_we_i  (elem_we),
        .seq_addr_i(wr_dst_addr),
        .seq_data_i(wr_data),
        .ext_we_i  (host_we),
        .ext_addr_i(host_addr),
        .ext_data_i(host_wdata),
        .regs_o    (regs)
    );

    always_comb begin
        d       = q;
        elem_we = 1'b0;
        done    = 1'b0;
        unique case (q.st)
            SEQ_IDLE: begin
                if (start) begin
                    d.st    = SEQ_RUN;
                    d.vl    = (vl > VL_CAP) ? VL_CAP : vl;
                    d.si    = '0;
                    d.di    = '0;
                    d.smask = src_always ? '1 : regs[src_mask_sel];
                    d.dmask = dst_always ? '1 : regs[dst_mask_sel];
                    d.sbase = src_base;
                    d.dbase = dst_base;
                    d.s_alw = src_always;
                    d.d_alw = dst_always;
                end
            end
            SEQ_RUN: begin
                if (s_found && d_found) begin
                    elem_we = 1'b1;
                    d.si    = s_pos + VL_W'(1);
                    d.di    = d_pos + VL_W'(1);
                end else begin
                    done = 1'b1;
                    d.st = SEQ_IDLE;
                end
            end
            default: d.st = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy         = (q.st == SEQ_RUN);
    assign elem_src_idx = s_pos;
    assign elem_dst_idx = d_pos;
    assign host_rdata   = regs[host_raddr];
endmodule

// File: rtl/pvs_checker.sv
module pvs_checker #(
    parameter int VL_W = 7
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start,
    input logic            busy,
    input logic            done,
    input logic            elem_we,
    input logic [VL_W-1:0] elem_src_idx,
    input logic [VL_W-1:0] elem_dst_idx,
    input logic [VL_W-1:0] run_vl,
    input logic            run_s_alw,
    input logic            run_d_alw
);
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!elem_we && !done));

    p_dense_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (elem_we && $past(elem_we) && run_s_alw) |->
            elem_src_idx == $past(elem_src_idx) + VL_W'(1));

    p_dense_dst_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (elem_we && $past(elem_we) && run_d_alw) |->
            elem_dst_idx == $past(elem_dst_idx) + VL_W'(1));

    p_done_then_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    p_done_no_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (busy && !elem_we));

    p_idx_in_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
        elem_we |-> (elem_src_idx < run_vl && elem_dst_idx < run_vl));

    p_idx_rising_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (elem_we && $past(elem_we)) |->
            (elem_src_idx > $past(elem_src_idx) && elem_dst_idx > $past(elem_dst_idx)));

    p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done && start) |=> (busy && $stable(run_vl)));
endmodule

bind pred_vec_seq pvs_checker #(.VL_W(VL_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .busy        (busy),
    .done        (done),
    .elem_we     (elem_we),
    .elem_src_idx(elem_src_idx),
    .elem_dst_idx(elem_dst_idx),
    .run_vl      (run_vl),
    .run_s_alw   (run_s_alw),
    .run_d_alw   (run_d_alw)
);

// File: tb/pred_vec_seq_test.sv
`timescale 1ns/1ps
module pred_vec_seq_test;
    localparam int DW = 64, NREG = 32, AW = 5, VW = 7;

    logic clk = 1'b0, rst_n = 1'b0;
    logic start = 1'b0, src_always = 1'b0, dst_always = 1'b0;
    logic [VW-1:0] vl = '0;
    logic [AW-1:0] src_base = '0, dst_base = '0, src_mask_sel = '0, dst_mask_sel = '0;
    logic busy, done, elem_we;
    logic [VW-1:0] elem_src_idx, elem_dst_idx;
    logic host_we = 1'b0;
    logic [AW-1:0] host_addr = '0, host_raddr = '0;
    logic [DW-1:0] host_wdata = '0, host_rdata;

    pred_vec_seq uut (.*);

    always #2 clk = ~clk;

    int nchk = 0, nfail = 0;
    logic [DW-1:0] mreg [NREG];
    int exp_s [64];
    int exp_d [64];
    int exp_n;

    task automatic check(input bit ok, input string req, input longint unsigned act,
                         input longint unsigned exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] sext8(input logic [DW-1:0] v);
        return {{(DW-8){v[7]}}, v[7:0]};
    endfunction

    task automatic host_write(input int a, input logic [DW-1:0] v);
        @(negedge clk);
        host_we = 1'b1; host_addr = AW'(a); host_wdata = v;
        @(negedge clk);
        host_we = 1'b0;
        mreg[a] = v;
    endtask

    // bench model: compute the pair list and update mreg
    task automatic model(input int vlen, input int sb, input int db, input int sm,
                         input int dm, input bit sa, input bit da);
        logic [DW-1:0] smk, dmk;
        int evl, si, di;
        smk = sa ? '1 : mreg[sm];
        dmk = da ? '1 : mreg[dm];
        evl = (vlen > DW) ? DW : vlen;
        si = 0; di = 0; exp_n = 0;
        forever begin
            while (si < evl && !smk[si]) si++;
            while (di < evl && !dmk[di]) di++;
            if (si >= evl || di >= evl) break;
            exp_s[exp_n] = si; exp_d[exp_n] = di; exp_n++;
            mreg[(db + di) % NREG] = sext8(mreg[(sb + si) % NREG]);
            si++; di++;
        end
    endtask

    task automatic run_op(input string req, input int vlen, input int sb, input int db,
                          input int sm, input int dm, input bit sa, input bit da,
                          input bit poke);
        int got, wd, bad_pair;
        model(vlen, sb, db, sm, dm, sa, da);
        @(negedge clk);
        vl = VW'(vlen); src_base = AW'(sb); dst_base = AW'(db);
        src_mask_sel = AW'(sm); dst_mask_sel = AW'(dm);
        src_always = sa; dst_always = da; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        got = 0; wd = 0; bad_pair = 0;
        while (!done && wd < 200) begin
            if (elem_we) begin
                if (got < exp_n)
                    check(elem_src_idx == VW'(exp_s[got]) && elem_dst_idx == VW'(exp_d[got]),
                          {req, " R9 pair"}, {elem_src_idx, elem_dst_idx},
                          {VW'(exp_s[got]), VW'(exp_d[got])});
                got++;
            end
            if (poke && wd == 0) begin
                // R10: start pulse during the run with other settings
                vl = 7'd5; src_always = 1'b1; dst_always = 1'b1; dst_base = AW'(db + 1);
                start = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            wd++;
        end
        start = 1'b0;
        check(done && busy, {req, " R7 done"}, {done, busy}, 2'b11);
        check(got == exp_n && wd == exp_n, {req, " R6 write count"}, got, exp_n);
        @(negedge clk);
        check(!busy && !done, {req, " R7 idle after done"}, busy, 0);
        // compare whole array through the host read port
        bad_pair = -1;
        for (int r = 0; r < NREG; r++) begin
            host_raddr = AW'(r);
            #0.1;
            if (host_rdata !== mreg[r] && bad_pair < 0) begin
                bad_pair = r;
                check(1'b0, $sformatf("%s array[%0d]", req, r), host_rdata, mreg[r]);
            end
        end
        if (bad_pair < 0) check(1'b1, req, 0, 0);
    endtask

    task automatic clear_all();
        for (int r = 0; r < NREG; r++) host_write(r, '0);
    endtask

    initial begin
        #(4ns * 150000);
        check(1'b0, "watchdog", 0, 1);
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20210322));
        for (int r = 0; r < NREG; r++) mreg[r] = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!busy && !done && !elem_we, "R1 reset outputs", {busy, done, elem_we}, 0);
        host_raddr = 5'd17; #0.1;
        check(host_rdata == '0, "R1 array reset", host_rdata, 0);
        rst_n = 1'b1;

        // R3 compress example
        host_write(3, 64'b101);
        host_write(9, 64'h90); host_write(10, 64'h91); host_write(11, 64'h92);
        run_op("R3 compress", 3, 9, 5, 3, 0, 1'b0, 1'b1, 1'b0);
        host_raddr = 5'd6; #0.1;
        check(host_rdata == 64'hFFFF_FFFF_FFFF_FF92, "R3 R8 dest1", host_rdata,
              64'hFFFF_FFFF_FFFF_FF92);
        host_raddr = 5'd7; #0.1;
        check(host_rdata == '0, "R6 dest2 untouched", host_rdata, 0);

        // R4 expand example
        clear_all();
        host_write(3, 64'b101);
        host_write(9, 64'h90); host_write(10, 64'h91); host_write(11, 64'h92);
        host_write(6, 64'h1234);
        run_op("R4 expand", 3, 9, 5, 0, 3, 1'b1, 1'b0, 1'b0);
        host_raddr = 5'd7; #0.1;
        check(host_rdata == 64'hFFFF_FFFF_FFFF_FF91, "R4 dest2", host_rdata,
              64'hFFFF_FFFF_FFFF_FF91);
        host_raddr = 5'd6; #0.1;
        check(host_rdata == 64'h1234, "R4 skipped dest keeps value", host_rdata, 64'h1234);

        // R2 both always, R8 positive and negative bytes
        host_write(20, 64'hAB7F); host_write(21, 64'h80); host_write(22, 64'h01);
        run_op("R2 R8 dense copy", 3, 20, 24, 0, 0, 1'b1, 1'b1, 1'b0);

        // R7 VL zero, VL one
        run_op("R7 vl zero", 0, 20, 24, 0, 0, 1'b1, 1'b1, 1'b0);
        run_op("R7 vl one", 1, 21, 28, 0, 0, 1'b1, 1'b1, 1'b0);

        // R5 both sparse, R6 zero mask
        host_write(1, 64'b1011_0110); host_write(2, 64'b0110_1001);
        run_op("R5 both sparse", 8, 8, 16, 1, 2, 1'b0, 1'b0, 1'b0);
        host_write(4, 64'h0);
        run_op("R6 empty src mask", 6, 8, 16, 4, 0, 1'b0, 1'b1, 1'b0);

        // R10 start while busy
        run_op("R10 start ignored", 6, 8, 16, 1, 0, 1'b0, 1'b1, 1'b1);

        // random operations, including overlapping regions and mask entries
        for (int t = 0; t < 60; t++) begin
            if (t % 6 == 0)
                for (int r = 0; r < NREG; r++)
                    host_write(r, {$urandom, $urandom});
            run_op($sformatf("R5 random %0d", t), $urandom_range(0, 14),
                   $urandom_range(0, 31), $urandom_range(0, 31), $urandom_range(0, 31),
                   $urandom_range(0, 31), 1'($urandom_range(0, 1)),
                   1'($urandom_range(0, 1)), 1'($urandom_range(0, 3) == 0));
        end

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule